// File: doc/BRIEF.md
# Exclusive-Access Reservation Monitor

This block is a small shared word memory with a reservation monitor in front of it. Several requesters issue loads, stores, exclusive loads and conditional stores each cycle. An exclusive load returns the word and records a reservation on the line that holds it for that requester. A later conditional store from the same requester writes only if that reservation is still intact. It then reports success. Otherwise it writes nothing and reports failure, and the requester retries its load/modify/conditional-store loop.

A reservation is lost when another requester stores to the reserved line. That store may be ordinary or a conditional store that succeeds. Each requester holds at most one reservation. Every conditional store ends the issuing requester's own reservation, whatever its outcome. The acquire and release flags on a request do not change the outcome. They come back unchanged with the response. Every request gets its response exactly one cycle later.

Top module: `exmon_top`

## Requirements
- R1: After reset no requester holds a reservation and no response is valid, so a conditional store issued before any exclusive load fails.
- R2: An exclusive load (op 2) returns the addressed word one cycle later and reserves its line for the requester. A line is the word address with its low log2(LINE_WORDS) bits dropped, which is 4 words by default.
- R3: A conditional store (op 3) to any word of the requester's reserved line writes that word and reports status 0.
- R4: A conditional store without a matching reservation reports status 1 and leaves memory unchanged.
- R5: A store to a reserved line by another requester clears the reservation, even when it is issued in the same cycle as the conditional store. This covers ordinary stores (op 1) and successful conditional stores. The following do not clear it: loads (op 0), stores to other lines, and the owner's own ordinary stores.
- R6: Every conditional store clears the issuer's reservation, and back-to-back retry sequences are accepted.
- R7: A new exclusive load replaces the requester's previous reservation.
- R8: When several reserved requesters issue conditional stores to one line in the same cycle, the lowest index succeeds and the others fail.
- R9: The acquire and release flags are returned with the response one cycle later and do not affect the outcome.
- R10: rspValid for each requester equals its reqValid from the previous cycle. rspFail is 0 for every operation other than a conditional store.
- R11: Stores in a cycle are ordered after all loads of that cycle. An exclusive load therefore returns the old word, but a same-cycle store to its line from another requester leaves it without a reservation. When several stores hit one word in one cycle, the lowest index's data is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | NREQ | Request valid, one bit per requester |
| reqOp | input | 2*NREQ | Operation per requester: 0 load, 1 store, 2 exclusive load, 3 conditional store |
| reqAddr | input | NREQ*ADDR_W | Word address per requester |
| reqWdata | input | NREQ*DATA_W | Store data per requester |
| reqAcq | input | NREQ | Acquire flag sideband |
| reqRel | input | NREQ | Release flag sideband |
| rspValid | output | NREQ | Response valid, one cycle after the request |
| rspData | output | NREQ*DATA_W | Read data for loads and exclusive loads, zero otherwise |
| rspFail | output | NREQ | Conditional store status: 0 success, 1 failure |
| rspAcq | output | NREQ | Returned acquire flag |
| rspRel | output | NREQ | Returned release flag |

## Verification
The properties assume that request inputs are held at zero while reset is asserted, because several of them compare a response with the request one cycle earlier. They also assume that reqOp only matters when reqValid is set. The bench drives every input from a cleared state, holds all valids low through reset, and changes requests only on the falling edge. Same-cycle conflicts are created on purpose with explicit multi-requester cycles, so the priority and ordering properties see real contention.

// File: rtl/exmon_pkg.sv
package exmon_pkg;

  localparam int MAX_REQ = 4;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_LDEX  = 2'd2,
    OP_STEX  = 2'd3
  } op_e;

  // strobes from control to datapath, one bit per requester
  typedef struct packed {
    logic [MAX_REQ-1:0] wrEn;
    logic [MAX_REQ-1:0] rdEn;
    logic [MAX_REQ-1:0] exFail;
  } strobe_t;

endpackage

// File: rtl/exmon_ctrl.sv
module exmon_ctrl #(
  parameter int NREQ  = 4,
  parameter int TAG_W = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NREQ-1:0]        reqValid,
  input  logic [2*NREQ-1:0]      reqOp,
  input  logic [NREQ*TAG_W-1:0]  reqTag,
  output exmon_pkg::strobe_t     strb
);
  import exmon_pkg::*;

  logic [NREQ-1:0]  isLoad, isSt, isLdex, isStex;
  logic [TAG_W-1:0] tag      [NREQ];
  logic [NREQ-1:0]  resvValid;
  logic [TAG_W-1:0] resvTag  [NREQ];
  logic [NREQ-1:0]  okV;
  logic [NREQ-1:0]  killV;
  logic [NREQ-1:0]  nxtValid;
  logic [TAG_W-1:0] nxtTag   [NREQ];

  always_comb begin
    for (int i = 0; i < NREQ; i++) begin
      tag[i]    = reqTag[i*TAG_W +: TAG_W];
      isLoad[i] = reqValid[i] && (reqOp[2*i +: 2] == OP_LOAD);
      isSt[i]   = reqValid[i] && (reqOp[2*i +: 2] == OP_STORE);
      isLdex[i] = reqValid[i] && (reqOp[2*i +: 2] == OP_LDEX);
      isStex[i] = reqValid[i] && (reqOp[2*i +: 2] == OP_STEX);
    end
  end

  // conditional store success: own reservation matches, no other store
  // to the line this cycle, no lower-index winner on the same line
  always_comb begin
    okV = '0;
    for (int i = 0; i < NREQ; i++) begin
      okV[i] = isStex[i] && resvValid[i] && (resvTag[i] == tag[i]);
      for (int j = 0; j < NREQ; j++) begin
        if (j != i && tag[j] == tag[i]) begin
          if (isSt[j]) okV[i] = 1'b0;
          if (j < i && okV[j]) okV[i] = 1'b0;
        end
      end
    end
  end

  // reservation update: stores by others land after this cycle's loads
  always_comb begin
    killV = '0;
    for (int i = 0; i < NREQ; i++) begin
      nxtTag[i] = isLdex[i] ? tag[i] : resvTag[i];
      for (int j = 0; j < NREQ; j++) begin
        if (j != i && (isSt[j] || okV[j]) && tag[j] == nxtTag[i])
          killV[i] = 1'b1;
      end
      if (isLdex[i])      nxtValid[i] = !killV[i];
      else if (isStex[i]) nxtValid[i] = 1'b0;
      else                nxtValid[i] = resvValid[i] && !killV[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resvValid <= '0;
      for (int i = 0; i < NREQ; i++) resvTag[i] <= '0;
    end else begin
      resvValid <= nxtValid;
      for (int i = 0; i < NREQ; i++) resvTag[i] <= nxtTag[i];
    end
  end

  always_comb begin
    strb        = '0;
    strb.wrEn   = MAX_REQ'(isSt | okV);
    strb.rdEn   = MAX_REQ'(isLoad | isLdex);
    strb.exFail = MAX_REQ'(isStex & ~okV);
  end

endmodule

// File: rtl/exmon_dpath.sv
module exmon_dpath #(
  parameter int NREQ   = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  exmon_pkg::strobe_t     strb,
  input  logic [NREQ-1:0]        reqValid,
  input  logic [NREQ*ADDR_W-1:0] reqAddr,
  input  logic [NREQ*DATA_W-1:0] reqWdata,
  input  logic [NREQ-1:0]        reqAcq,
  input  logic [NREQ-1:0]        reqRel,
  output logic [NREQ-1:0]        rspValid,
  output logic [NREQ*DATA_W-1:0] rspData,
  output logic [NREQ-1:0]        rspFail,
  output logic [NREQ-1:0]        rspAcq,
  output logic [NREQ-1:0]        rspRel
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // last nonblocking write wins, so index 0 is written last
  always_ff @(posedge clk) begin
    for (int k = NREQ - 1; k >= 0; k--) begin
      if (strb.wrEn[k])
        mem[reqAddr[k*ADDR_W +: ADDR_W]] <= reqWdata[k*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= '0;
      rspData  <= '0;
      rspFail  <= '0;
      rspAcq   <= '0;
      rspRel   <= '0;
    end else begin
      rspValid <= reqValid;
      rspFail  <= strb.exFail[NREQ-1:0];
      rspAcq   <= reqAcq & reqValid;
      rspRel   <= reqRel & reqValid;
      for (int k = 0; k < NREQ; k++) begin
        rspData[k*DATA_W +: DATA_W] <= strb.rdEn[k]
          ? mem[reqAddr[k*ADDR_W +: ADDR_W]] : '0;
      end
    end
  end

endmodule

// File: rtl/exmon_top.sv
module exmon_top #(
  parameter int NREQ       = 4,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NREQ-1:0]        reqValid,
  input  logic [2*NREQ-1:0]      reqOp,
  input  logic [NREQ*ADDR_W-1:0] reqAddr,
  input  logic [NREQ*DATA_W-1:0] reqWdata,
  input  logic [NREQ-1:0]        reqAcq,
  input  logic [NREQ-1:0]        reqRel,
  output logic [NREQ-1:0]        rspValid,
  output logic [NREQ*DATA_W-1:0] rspData,
  output logic [NREQ-1:0]        rspFail,
  output logic [NREQ-1:0]        rspAcq,
  output logic [NREQ-1:0]        rspRel
);
  localparam int LINE_SH = $clog2(LINE_WORDS);
  localparam int TAG_W   = ADDR_W - LINE_SH;

  exmon_pkg::strobe_t     strb;
  logic [NREQ*TAG_W-1:0]  reqTag;

  for (genvar g = 0; g < NREQ; g++) begin : g_tag
    assign reqTag[g*TAG_W +: TAG_W] = reqAddr[g*ADDR_W + LINE_SH +: TAG_W];
  end

  exmon_ctrl #(.NREQ(NREQ), .TAG_W(TAG_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqTag(reqTag), .strb(strb)
  );

  exmon_dpath #(.NREQ(NREQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .reqValid(reqValid),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqAcq(reqAcq), .reqRel(reqRel),
    .rspValid(rspValid), .rspData(rspData), .rspFail(rspFail),
    .rspAcq(rspAcq), .rspRel(rspRel)
  );

endmodule

// File: rtl/exmon_chk.sv
module exmon_chk #(
  parameter int NREQ       = 4,
  parameter int ADDR_W     = 8,
  parameter int LINE_WORDS = 4
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [NREQ-1:0]        reqValid,
  input logic [2*NREQ-1:0]      reqOp,
  input logic [NREQ*ADDR_W-1:0] reqAddr,
  input logic [NREQ-1:0]        reqAcq,
  input logic [NREQ-1:0]        reqRel,
  input logic [NREQ-1:0]        rspValid,
  input logic [NREQ-1:0]        rspFail,
  input logic [NREQ-1:0]        rspAcq,
  input logic [NREQ-1:0]        rspRel
);
  localparam int LINE_SH = $clog2(LINE_WORDS);
  localparam int TAG_W   = ADDR_W - LINE_SH;

  logic [NREQ-1:0]  stex;
  logic [TAG_W-1:0] lineOf [NREQ];

  always_comb begin
    for (int i = 0; i < NREQ; i++) begin
      stex[i]   = reqValid[i] && (reqOp[2*i +: 2] == exmon_pkg::OP_STEX);
      lineOf[i] = reqAddr[i*ADDR_W + LINE_SH +: TAG_W];
    end
  end

  for (genvar i = 0; i < NREQ; i++) begin : g_req
    // R10: one-cycle response for every request
    p_rsp_follows_req_r10: assert property (@(posedge clk) disable iff (!rstN)
      rspValid[i] == $past(reqValid[i]));
    // R4: a failure status only answers a conditional store
    p_fail_needs_stex_r4: assert property (@(posedge clk) disable iff (!rstN)
      rspFail[i] |-> $past(stex[i]));
    // R9: flags come back unchanged
    p_flags_echo_r9: assert property (@(posedge clk) disable iff (!rstN)
      rspValid[i] |-> (rspAcq[i] == $past(reqAcq[i]) && rspRel[i] == $past(reqRel[i])));
    // R6: two conditional stores in a row, the second one fails
    p_second_stex_fails_r6: assert property (@(posedge clk) disable iff (!rstN)
      (stex[i] && $past(stex[i])) |=> rspFail[i]);
    for (genvar j = i + 1; j < NREQ; j++) begin : g_pair
      // R8: at most one winner per line per cycle
      p_one_winner_r8: assert property (@(posedge clk) disable iff (!rstN)
        (stex[i] && stex[j] && lineOf[i] == lineOf[j]) |=> (rspFail[i] || rspFail[j]));
    end
  end

endmodule

bind exmon_top exmon_chk #(.NREQ(NREQ), .ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS)) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
  .reqAcq(reqAcq), .reqRel(reqRel), .rspValid(rspValid), .rspFail(rspFail),
  .rspAcq(rspAcq), .rspRel(rspRel)
);

// File: tb/exmon_top_tb_top.sv
module exmon_top_tb_top;
  localparam int NREQ = 4, AW = 8, DW = 32;
  localparam logic [1:0] LD = 2'd0, ST = 2'd1, LX = 2'd2, SX = 2'd3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic          vld [NREQ];
  logic [1:0]    op  [NREQ];
  logic [AW-1:0] adr [NREQ];
  logic [DW-1:0] wd  [NREQ];
  logic          acq [NREQ];
  logic          rel [NREQ];

  logic [NREQ-1:0]    reqValid, reqAcq, reqRel;
  logic [2*NREQ-1:0]  reqOp;
  logic [NREQ*AW-1:0] reqAddr;
  logic [NREQ*DW-1:0] reqWdata;
  logic [NREQ-1:0]    rspValid, rspFail, rspAcq, rspRel;
  logic [NREQ*DW-1:0] rspData;

  always_comb begin
    for (int i = 0; i < NREQ; i++) begin
      reqValid[i]          = vld[i];
      reqOp[2*i +: 2]      = op[i];
      reqAddr[i*AW +: AW]  = adr[i];
      reqWdata[i*DW +: DW] = wd[i];
      reqAcq[i]            = acq[i];
      reqRel[i]            = rel[i];
    end
  end

  exmon_top dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqAcq(reqAcq), .reqRel(reqRel), .rspValid(rspValid),
    .rspData(rspData), .rspFail(rspFail), .rspAcq(rspAcq), .rspRel(rspRel)
  );

  int nChk = 0, nFail = 0;
  bit done = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clearReq();
    for (int i = 0; i < NREQ; i++) begin
      vld[i] = 0; op[i] = LD; adr[i] = '0; wd[i] = '0; acq[i] = 0; rel[i] = 0;
    end
  endtask

  task automatic setReq(int r, logic [1:0] o, logic [AW-1:0] a, logic [DW-1:0] d,
                        logic aq = 0, logic rl = 0);
    vld[r] = 1; op[r] = o; adr[r] = a; wd[r] = d; acq[r] = aq; rel[r] = rl;
  endtask

  // requests set at a falling edge, responses read at the next one
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    clearReq();
  endtask

  function automatic logic [DW-1:0] dataOf(int r);
    return rspData[r*DW +: DW];
  endfunction

  task automatic doStore(int r, logic [AW-1:0] a, logic [DW-1:0] d);
    setReq(r, ST, a, d); step();
  endtask

  task automatic doLoad(int r, logic [AW-1:0] a, output logic [DW-1:0] q);
    setReq(r, LD, a, 0); step(); q = dataOf(r);
  endtask

  task automatic doLdex(int r, logic [AW-1:0] a, output logic [DW-1:0] q);
    setReq(r, LX, a, 0); step(); q = dataOf(r);
  endtask

  task automatic doStex(int r, logic [AW-1:0] a, logic [DW-1:0] d, output logic f);
    setReq(r, SX, a, d); step(); f = rspFail[r];
  endtask

  task automatic tReset();
    logic [DW-1:0] q; logic f;
    check("R1 rspValid in reset", 32'(rspValid), 0);
    rstN = 1;
    @(negedge clk);
    check("R1 rspValid after reset", 32'(rspValid), 0);
    doStore(1, 8'h10, 32'h11);
    doStex(0, 8'h10, 32'h99, f);
    check("R1 stex without reservation fails", 32'(f), 1);
    doLoad(2, 8'h10, q);
    check("R4 memory unchanged after failed stex", q, 32'h11);
  endtask

  task automatic tBasic();
    logic [DW-1:0] q; logic f;
    doStore(1, 8'h20, 32'h5);
    doLdex(0, 8'h20, q);
    check("R2 ldex returns data", q, 32'h5);
    doStex(0, 8'h21, 32'h6, f);
    check("R3 stex same line succeeds", 32'(f), 0);
    doLoad(0, 8'h21, q);
    check("R3 stex wrote word", q, 32'h6);
  endtask

  task automatic tOtherLine();
    logic [DW-1:0] q; logic f;
    doStore(1, 8'h24, 32'h77);
    doLdex(0, 8'h20, q);
    doStex(0, 8'h24, 32'h88, f);
    check("R4 stex to other line fails", 32'(f), 1);
    doLoad(3, 8'h24, q);
    check("R4 other line unchanged", q, 32'h77);
  endtask

  task automatic tInterfere();
    logic [DW-1:0] q; logic f;
    doStore(2, 8'h30, 32'h5);
    doLdex(0, 8'h30, q);
    doLoad(1, 8'h30, q);
    doStore(1, 8'h34, 32'h1);
    doStex(0, 8'h31, 32'hA, f);
    check("R5 load and other-line store keep reservation", 32'(f), 0);
    doLdex(0, 8'h30, q);
    doStore(1, 8'h33, 32'hB);
    doStex(0, 8'h30, 32'hC, f);
    check("R5 foreign store clears reservation", 32'(f), 1);
    doLoad(0, 8'h30, q);
    check("R5 memory unchanged after killed stex", q, 32'h5);
    doLdex(0, 8'h30, q);
    doStore(0, 8'h32, 32'h7);
    doStex(0, 8'h30, 32'hD, f);
    check("R5 own ordinary store keeps reservation", 32'(f), 0);
    doLdex(2, 8'h74, q);
    setReq(2, SX, 8'h74, 32'h1); setReq(3, ST, 8'h75, 32'h2); step();
    check("R5 same-cycle foreign store defeats stex", 32'(rspFail[2]), 1);
  endtask

  task automatic tRetry();
    logic [DW-1:0] q; logic f;
    doLdex(2, 8'h50, q);
    doStex(2, 8'h50, 32'h1, f);
    check("R6 first stex succeeds", 32'(f), 0);
    doStex(2, 8'h50, 32'h2, f);
    check("R6 repeated stex fails", 32'(f), 1);
    doLoad(2, 8'h50, q);
    check("R6 memory holds first value", q, 32'h1);
    doLdex(2, 8'h50, q);
    doStore(3, 8'h51, 32'h9);
    doStex(2, 8'h50, 32'h3, f);
    check("R6 retry attempt fails after interference", 32'(f), 1);
    doLdex(2, 8'h50, q);
    check("R6 retry reload", q, 32'h1);
    doStex(2, 8'h50, 32'h4, f);
    check("R6 retry succeeds", 32'(f), 0);
    doLoad(1, 8'h50, q);
    check("R6 retry value stored", q, 32'h4);
  endtask

  task automatic tReplace();
    logic [DW-1:0] q; logic f;
    doLdex(1, 8'h60, q);
    doLdex(1, 8'h64, q);
    doStex(1, 8'h60, 32'h1, f);
    check("R7 old reservation replaced", 32'(f), 1);
    doLdex(1, 8'h60, q);
    doLdex(1, 8'h64, q);
    doStex(1, 8'h64, 32'h2, f);
    check("R7 new reservation used", 32'(f), 0);
  endtask

  task automatic tPriority();
    logic [DW-1:0] q; logic f;
    doStore(0, 8'h71, 32'h0);
    for (int r = 0; r < NREQ; r++) setReq(r, LX, 8'h70, 0);
    step();
    setReq(1, SX, 8'h70, 32'hAA); setReq(2, SX, 8'h71, 32'hBB); setReq(3, SX, 8'h72, 32'hCC);
    step();
    check("R8 lowest index wins", 32'(rspFail[1]), 0);
    check("R8 second requester fails", 32'(rspFail[2]), 1);
    check("R8 third requester fails", 32'(rspFail[3]), 1);
    doLoad(0, 8'h70, q);
    check("R8 winner data", q, 32'hAA);
    doLoad(0, 8'h71, q);
    check("R8 loser did not write", q, 32'h0);
    doStex(0, 8'h70, 32'h1, f);
    check("R5 successful foreign stex clears reservation", 32'(f), 1);
  endtask

  task automatic tFlags();
    setReq(0, LX, 8'h80, 0, 1, 0); step();
    check("R9 acquire echoed", 32'(rspAcq[0]), 1);
    check("R9 release clear", 32'(rspRel[0]), 0);
    setReq(0, SX, 8'h80, 32'h5, 0, 1); step();
    check("R9 release echoed", 32'(rspRel[0]), 1);
    check("R9 flags do not change outcome", 32'(rspFail[0]), 0);
  endtask

  task automatic tTiming();
    setReq(0, ST, 8'h90, 32'h3); setReq(2, LD, 8'h90, 0); step();
    check("R10 rspValid pattern", 32'(rspValid), 32'h5);
    check("R10 no fail for non-stex", 32'(rspFail), 0);
    @(negedge clk);
    check("R10 idle cycle", 32'(rspValid), 0);
  endtask

  task automatic tOrdering();
    logic [DW-1:0] q; logic f;
    doStore(0, 8'h90, 32'hA);
    setReq(0, LX, 8'h90, 0); setReq(1, ST, 8'h90, 32'hB); step();
    check("R11 ldex sees old word", dataOf(0), 32'hA);
    doStex(0, 8'h90, 32'hC, f);
    check("R11 same-cycle store clears new reservation", 32'(f), 1);
    doLoad(0, 8'h90, q);
    check("R11 store landed", q, 32'hB);
    setReq(3, ST, 8'hA0, 32'h3); setReq(1, ST, 8'hA0, 32'h1); step();
    doLoad(2, 8'hA0, q);
    check("R11 lowest index write kept", q, 32'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    clearReq();
    repeat (4) @(negedge clk);
    tReset();
    tBasic();
    tOtherLine();
    tInterfere();
    tRetry();
    tReplace();
    tPriority();
    tFlags();
    tTiming();
    tOrdering();
    done = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule